// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target side of a synchronous peripheral bus whose 32 lines carry an address and then data at different times. An initiator opens a transaction by pulling the active-low frame line low. On that clock the shared lines hold the address and a 4-bit field holds the command. The target captures both and checks whether the address falls inside its own window of word registers. If the address hits and the command is a memory read or a memory write, the target claims the transaction and moves data words on the same lines. During data phases the 4-bit field carries active-low byte enables.

Two active-low ready lines set the pace. Initiator-ready comes from the initiator and target-ready from this block, and a word moves only on a clock where both are low. When the initiator holds frame low, the transaction becomes a burst. The target steps its internal word address by four bytes on each word that moves, and the initiator does not drive the address again. When frame is high on a clock where a word moves, that word is the last one, and the target returns to idle.

The shared lines are modelled as a separate input, output and output-enable. The target enables its output only during read data phases.

Top module: `mbt_target`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `trdy_n` is 1 and `ad_oe` is 0.
- R2: A memory write (command 4'b0111) to an address in the window asserts `trdy_n` low in the clock right after the address clock. A single write therefore occupies 2 clocks.
- R3: For a write word, the byte in lane k (bits 8k+7..8k) of the addressed register changes only if `cbe_n[k]` is 0 on the clock where the word moves. The other lanes keep their old value.
- R4: A memory read (command 4'b0110) that hits the window leaves one turnaround clock after the address clock, with `ad_oe` at 0 and `trdy_n` at 1. The next clock has `ad_oe` at 1, `trdy_n` at 0 and the register contents on `ad_out`, so a single read occupies 3 clocks.
- R5: A word moves only on a clock where `irdy_n` and `trdy_n` are both 0. While `irdy_n` is 1 in a data phase, `trdy_n`, `ad_oe` and `ad_out` hold their values and no register changes.
- R6: While `frame_n` stays low, each word that moves advances the register index by one, which is 4 bytes of address. The index wraps from the last register of the window back to the first.
- R7: A word that moves while `frame_n` is 1 ends the transaction. On the next clock `trdy_n` is 1 and `ad_oe` is 0.
- R8: An address outside the window, given by bits 31..IDX_W+2 differing from `BASE_ADDR`, is not claimed. `trdy_n` stays 1, `ad_oe` stays 0 and no register changes until `frame_n` and `irdy_n` are both 1 again.
- R9: Any command other than 4'b0110 and 4'b0111 is not claimed, even at an address inside the window. It behaves as in R8.
- R10: `ad_oe` is 1 only in read data phases, and then `trdy_n` is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ad_in | input | 32 | Shared lines as seen by the target (address, then write data) |
| ad_out | output | 32 | Read data the target drives onto the shared lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| cbe_n | input | 4 | Command on the address clock, active-low byte enables on data clocks |
| frame_n | input | 1 | Active-low transaction frame; high during a word means that word is the last |
| irdy_n | input | 1 | Active-low initiator ready |
| trdy_n | output | 1 | Active-low target ready |

## Verification
A single clock edge can move a word and end the transaction at once, because `frame_n` is high while both ready lines are low. Bursts provoke this at the end of every transfer. The check is that the final word lands in the right register and that `trdy_n` and `ad_oe` release on the very next clock. The index wrap from the top register to the first can also fall on the same edge as an initiator wait state. Bursts that start near the top of the window, with a wait inserted on the word after the wrap, exercise this. The data observed on the lines, together with later read-back, must match a per-byte model kept in the bench.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_TURN,
    ST_RDATA,
    ST_WDATA
  } mbt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/mbt_decode.sv
module mbt_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          IDX_W     = 3,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  output logic              hit_rd,
  output logic              hit_wr
);
  localparam int LOW = IDX_W + 2;

  logic in_window;

  always_comb begin
    in_window = (addr[ADDR_W-1:LOW] == BASE_ADDR[ADDR_W-1:LOW]);
    hit_rd    = in_window && (cmd == mbt_pkg::CMD_MEM_RD);
    hit_wr    = in_window && (cmd == mbt_pkg::CMD_MEM_WR);
  end
endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int NREG  = 1 << IDX_W;
  localparam int LANES = DATA_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q [NREG];
    logic       lane_we;

    always_comb lane_we = wr_en && wr_be[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < NREG; e++) lane_q[e] <= '0;
      end else if (lane_we) begin
        lane_q[wr_idx] <= wr_data[b*8 +: 8];
      end
    end

    always_comb rd_data[b*8 +: 8] = lane_q[rd_idx];
  end
endmodule

// File: rtl/mbt_target.sv
module mbt_target #(
  parameter int          IDX_W     = 3,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  input  logic [3:0]  cbe_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  output logic        trdy_n
);
  import mbt_pkg::*;

  localparam int DATA_W = 32;

  mbt_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             trdy_n_q, trdy_n_d;
  logic             oe_q, oe_d;
  logic             hit_rd, hit_wr;
  logic             in_data, xfer, wr_en;
  logic [31:0]      rd_data;

  mbt_decode #(
    .ADDR_W   (DATA_W),
    .IDX_W    (IDX_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr  (ad_in),
    .cmd   (cbe_n),
    .hit_rd(hit_rd),
    .hit_wr(hit_wr)
  );

  always_comb begin
    in_data = (state_q == ST_RDATA) || (state_q == ST_WDATA);
    xfer    = in_data && !irdy_n && !trdy_n_q;
    wr_en   = xfer && (state_q == ST_WDATA);
  end

  mbt_regfile #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (idx_q),
    .wr_be  (~cbe_n),
    .wr_data(ad_in),
    .rd_idx (idx_q),
    .rd_data(rd_data)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    trdy_n_d = trdy_n_q;
    oe_d     = oe_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!frame_n) begin
          idx_d = ad_in[IDX_W+1:2];
          if (hit_wr) begin
            state_d  = ST_WDATA;
            trdy_n_d = 1'b0;
          end else if (hit_rd) begin
            state_d = ST_TURN;
          end else begin
            state_d = ST_SKIP;
          end
        end
      end
      ST_SKIP: begin
        if (frame_n && irdy_n) state_d = ST_IDLE;
      end
      ST_TURN: begin
        state_d  = ST_RDATA;
        trdy_n_d = 1'b0;
        oe_d     = 1'b1;
      end
      ST_RDATA, ST_WDATA: begin
        if (xfer) begin
          if (frame_n) begin
            state_d  = ST_IDLE;
            trdy_n_d = 1'b1;
            oe_d     = 1'b0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        state_d  = ST_IDLE;
        trdy_n_d = 1'b1;
        oe_d     = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      trdy_n_q <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      trdy_n_q <= trdy_n_d;
      oe_q     <= oe_d;
    end
  end

  always_comb begin
    trdy_n = trdy_n_q;
    ad_oe  = oe_q;
    ad_out = oe_q ? rd_data : '0;
  end
endmodule

// File: rtl/mbt_checker.sv
module mbt_checker (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_n,
  input logic                irdy_n,
  input logic                trdy_n,
  input logic                ad_oe,
  input logic [31:0]         ad_out,
  input mbt_pkg::mbt_state_e state_q
);
  // R10: the lines are driven only while target-ready is low
  a_r10_oe_needs_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n);

  // R7: the last word releases target-ready and the lines
  a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && !ad_oe));

  // R5: an initiator wait holds the data phase
  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_oe) && $stable(ad_out)));

  // R4: the lines are driven only after a clock with target-ready high
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(trdy_n));

  // R8, R9: an unclaimed transaction never asserts ready or drives the lines
  a_r8_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == mbt_pkg::ST_SKIP) |-> (trdy_n && !ad_oe));
endmodule

bind mbt_target mbt_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .frame_n(frame_n),
  .irdy_n (irdy_n),
  .trdy_n (trdy_n),
  .ad_oe  (ad_oe),
  .ad_out (ad_out),
  .state_q(state_q)
);

// File: tb/sim_mbt_target.sv
module sim_mbt_target;
  localparam int          IDX_W = 3;
  localparam int          NREG  = 1 << IDX_W;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam logic [3:0]  C_RD  = 4'b0110;
  localparam logic [3:0]  C_WR  = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        trdy_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] model [NREG];

  // vector: write flag, register index, byte enables (active low), data
  localparam logic [39:0] VEC [8] = '{
    {1'b1, 3'd0, 4'b0000, 32'h1122_3344},
    {1'b1, 3'd1, 4'b0000, 32'hCAFE_F00D},
    {1'b0, 3'd0, 4'b0000, 32'h0},
    {1'b1, 3'd0, 4'b1010, 32'hAABB_CCDD},
    {1'b0, 3'd0, 4'b0000, 32'h0},
    {1'b1, 3'd1, 4'b0111, 32'h9900_0000},
    {1'b0, 3'd1, 4'b0000, 32'h0},
    {1'b0, 3'd5, 4'b0000, 32'h0}
  };

  mbt_target #(.IDX_W(IDX_W), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input int i, input logic [3:0] be_n, input logic [31:0] d);
    for (int b = 0; b < 4; b++)
      if (!be_n[b]) model[i][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic bus_idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    end
  endtask

  // write burst of n words from index s; wait state before word w (-1 = none)
  task automatic wr_burst(input int s, input int n, input int w,
                          input logic [3:0] be_n, input logic [31:0] seed);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = C_WR; ad_in = BASE + 32'(s * 4);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == w) begin
        irdy_n = 1'b1; ad_in = seed + 32'(k);
        chk(!trdy_n, "R5 trdy held", {31'd0, trdy_n}, 32'd0);
        @(negedge clk);
      end
      chk(!trdy_n && !ad_oe, "R2 trdy on data clock", {30'd0, ad_oe, trdy_n}, 32'd0);
      frame_n = (k == n - 1); irdy_n = 1'b0; cbe_n = be_n; ad_in = seed + 32'(k);
      model_wr((s + k) % NREG, be_n, seed + 32'(k));
    end
    @(negedge clk);
    chk(trdy_n && !ad_oe, "R7 release after write", {30'd0, ad_oe, trdy_n}, 32'd1);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
  endtask

  // read burst of n words from index s; wait state before word w (-1 = none)
  task automatic rd_burst(input int s, input int n, input int w);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = C_RD; ad_in = BASE + 32'(s * 4);
    @(negedge clk);
    chk(trdy_n && !ad_oe, "R4 turnaround", {30'd0, ad_oe, trdy_n}, 32'd1);
    irdy_n = 1'b0; cbe_n = 4'h0; ad_in = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == w) begin
        irdy_n = 1'b1;
        chk(ad_oe && !trdy_n && ad_out == model[(s + k) % NREG], "R5 read wait",
            ad_out, model[(s + k) % NREG]);
        @(negedge clk);
      end
      chk(ad_oe && !trdy_n, "R4 drive", {30'd0, ad_oe, trdy_n}, 32'd2);
      chk(ad_out == model[(s + k) % NREG], "R6 read data", ad_out,
          model[(s + k) % NREG]);
      frame_n = (k == n - 1); irdy_n = 1'b0;
    end
    @(negedge clk);
    chk(trdy_n && !ad_oe, "R7 release after read", {30'd0, ad_oe, trdy_n}, 32'd1);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
  endtask

  // unclaimed two-word transaction: nothing may respond
  task automatic unclaimed(input logic [31:0] addr, input logic [3:0] cmd,
                           input string req);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad_in = addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(trdy_n && !ad_oe, req, {30'd0, ad_oe, trdy_n}, 32'd1);
      frame_n = (k >= 1); irdy_n = 1'b0; cbe_n = 4'h0; ad_in = 32'hDEAD_BEEF;
    end
    bus_idle(2);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(trdy_n && !ad_oe, "R1 in reset", {30'd0, ad_oe, trdy_n}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trdy_n && !ad_oe, "R1 after reset", {30'd0, ad_oe, trdy_n}, 32'd1);

    // table walk: single writes with byte enables (R2, R3), single reads (R4)
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][39]) wr_burst(int'(VEC[v][38:36]), 1, -1, VEC[v][35:32], VEC[v][31:0]);
      else            rd_burst(int'(VEC[v][38:36]), 1, -1);
    end

    // R6 burst write wrapping past the top with a wait state after the wrap (R5)
    wr_burst(6, 4, 2, 4'b0000, 32'hA000_0000);
    rd_burst(6, 4, 2);
    // R3 partial-lane burst then back-to-back read
    wr_burst(2, 3, -1, 4'b1100, 32'h0000_5A00);
    rd_burst(1, 5, 0);

    // R8 miss, R9 unsupported command at a hit address
    unclaimed(BASE + 32'h100, C_WR, "R8 miss ignored");
    unclaimed(BASE + 32'd8, 4'b0011, "R9 other command ignored");
    unclaimed(BASE + 32'd8, 4'b0010, "R9 other read ignored");
    rd_burst(0, 8, 7);

    bus_idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule